// File: doc/BRIEF.md
# Manchester Burst Receiver with Edge-Aligned Decode Clock

This block sits on the isolated side of a combined power-and-data link. During each energy-transfer burst the line carries Manchester-coded bits. Between bursts there is a long quiet gap in which the line stays low. The block first passes the squared-up line level through a synchronizer. It then waits for the first rising edge of a burst and starts a local bit-rate clock aligned to that edge. From then on it decodes each bit by XOR of that local clock with the line level.

The local clock is high for the first half of every bit period and low for the second half. The XOR result is sampled at the three-quarter point of each bit, away from the mid-bit transition. No phase tracking happens inside a burst. Alignment is set once per burst. When the line has not changed for longer than a parameterized number of bit periods, the burst is treated as over and the receiver re-arms for the next first rising edge. Each burst must open with a 0 bit, so that its first rising edge falls on a bit boundary.

Top module: `manchester_rx`

## Requirements
- R1: After reset, `bit_o`, `bit_valid_o` and `burst_active_o` are all 0.
- R2: While idle, the receiver emits no bit. A rising edge on `line_i` sets `burst_active_o` on the third rising clock edge after the line change: two synchronizer stages, then one register.
- R3: The encoding is as follows. A 1 is sent as low in the first half of the bit and high in the second half. A 0 is sent as high then low. `bit_o` is the line level XOR a local clock that is high in the first half. It is sampled at clock count 3*BIT_CLKS/4 of each bit, and bits come out in the order sent.
- R4: The first rising edge after arming marks the start of a bit period. The first bit decoded in every burst is 0.
- R5: `bit_valid_o` is a single-cycle pulse, at most one per bit period.
- R6: A bit period with no line transition between counts BIT_CLKS/4 and 3*BIT_CLKS/4 produces no `bit_valid_o`. Bit alignment is kept for the following bits.
- R7: `burst_active_o` falls once TIMEOUT_BITS*BIT_CLKS consecutive cycles pass with no synchronized transition, and not earlier.
- R8: After a burst ends, the next rising edge re-aligns the decode clock, whatever the phase of that edge against the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock, BIT_CLKS cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Digitized line level, asynchronous |
| bit_o | output | 1 | Last decoded bit |
| bit_valid_o | output | 1 | One-cycle strobe: `bit_o` holds a new bit |
| burst_active_o | output | 1 | High while a burst is being decoded |

## Verification
An error in the bit-position counter shows up as inverted or missing bits within one bit period, because the sample point then lands in the wrong half. A stuck activity flag shows up in one of two ways. Either the timeout does not fire within TIMEOUT_BITS bit periods after the line goes quiet, or the next burst decodes with a half-bit offset, which makes its first bit read as 1. A broken mid-bit qualifier shows up as a stray bit during a quiet period or during the timeout window. The scoreboard reports these as unexpected items or as items left in the queue.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef struct packed {
    logic lvl;     // synchronized line level
    logic rise;    // low-to-high this cycle
    logic toggle;  // any change this cycle
  } line_evt_t;
endpackage

// File: rtl/mrx_line_sync.sv
module mrx_line_sync
  import mrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_i,
  output line_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];

  always_comb begin
    evt_o.lvl    = sync_q[SYNC_STAGES-1];
    evt_o.rise   = sync_q[SYNC_STAGES-1] & ~last_q;
    evt_o.toggle = sync_q[SYNC_STAGES-1] ^ last_q;
  end
endmodule

// File: rtl/mrx_bit_timer.sv
module mrx_bit_timer
  import mrx_pkg::*;
#(
  parameter int BIT_CLKS     = 16,
  parameter int TIMEOUT_BITS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  line_evt_t                   evt_i,
  output logic                        active_o,
  output logic [$clog2(BIT_CLKS)-1:0] pos_o
);
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam int TO_CLKS = TIMEOUT_BITS * BIT_CLKS;
  localparam int TO_W = $clog2(TO_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] ONE_POS  = CNT_W'(1);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TO_CLKS - 1);

  logic [TO_W-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      pos_o    <= '0;
      quiet_q  <= '0;
    end else if (!active_o) begin
      quiet_q <= '0;
      if (evt_i.rise) begin
        // edge cycle is position 0 of the first bit
        active_o <= 1'b1;
        pos_o    <= ONE_POS;
      end else begin
        pos_o <= '0;
      end
    end else begin
      pos_o <= (pos_o == LAST_POS) ? '0 : pos_o + ONE_POS;
      if (evt_i.toggle) begin
        quiet_q <= '0;
      end else if (quiet_q == TO_LAST) begin
        active_o <= 1'b0;
        quiet_q  <= '0;
      end else begin
        quiet_q <= quiet_q + TO_W'(1);
      end
    end
  end
endmodule

// File: rtl/mrx_slicer.sv
module mrx_slicer
  import mrx_pkg::*;
#(
  parameter int BIT_CLKS = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  line_evt_t                   evt_i,
  input  logic                        active_i,
  input  logic [$clog2(BIT_CLKS)-1:0] pos_i,
  output logic                        bit_o,
  output logic                        valid_o
);
  localparam int CNT_W = $clog2(BIT_CLKS);
  localparam logic [CNT_W-1:0] HALF_POS   = CNT_W'(BIT_CLKS / 2);
  localparam logic [CNT_W-1:0] WIN_LO     = CNT_W'(BIT_CLKS / 4);
  localparam logic [CNT_W-1:0] SAMPLE_POS = CNT_W'((3 * BIT_CLKS) / 4);

  logic syn_clk, decoded, in_win, mid_seen_q;

  always_comb begin
    syn_clk = (pos_i < HALF_POS);
    decoded = evt_i.lvl ^ syn_clk;
    in_win  = (pos_i >= WIN_LO) && (pos_i < SAMPLE_POS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o      <= 1'b0;
      valid_o    <= 1'b0;
      mid_seen_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!active_i) begin
        mid_seen_q <= 1'b0;
      end else if (pos_i == SAMPLE_POS) begin
        // emit only if the mandatory mid-bit transition was seen
        if (mid_seen_q) begin
          bit_o   <= decoded;
          valid_o <= 1'b1;
        end
        mid_seen_q <= 1'b0;
      end else if (in_win && evt_i.toggle) begin
        mid_seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx
  import mrx_pkg::*;
#(
  parameter int BIT_CLKS     = 16,
  parameter int TIMEOUT_BITS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic burst_active_o
);
  localparam int CNT_W = $clog2(BIT_CLKS);

  line_evt_t        line_evt;
  logic [CNT_W-1:0] bit_pos;

  mrx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .evt_o (line_evt)
  );

  mrx_bit_timer #(.BIT_CLKS(BIT_CLKS), .TIMEOUT_BITS(TIMEOUT_BITS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (line_evt),
    .active_o(burst_active_o),
    .pos_o   (bit_pos)
  );

  mrx_slicer #(.BIT_CLKS(BIT_CLKS)) u_slicer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (line_evt),
    .active_i(burst_active_o),
    .pos_i   (bit_pos),
    .bit_o   (bit_o),
    .valid_o (bit_valid_o)
  );
endmodule

// File: rtl/manchester_rx_chk.sv
module manchester_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rise_i,
  input logic bit_o,
  input logic bit_valid_o,
  input logic burst_active_o
);
  logic act_q, first_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q        <= 1'b0;
      first_pend_q <= 1'b0;
    end else begin
      act_q <= burst_active_o;
      if (burst_active_o && !act_q) first_pend_q <= 1'b1;
      else if (bit_valid_o)         first_pend_q <= 1'b0;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_active_o |=> !bit_valid_o);

  // R4
  arm_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_active_o) |-> $past(rise_i));

  // R4
  first_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && first_pend_q) |-> !bit_o);

  // R7
  valid_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> burst_active_o);
endmodule

bind manchester_rx manchester_rx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rise_i        (line_evt.rise),
  .bit_o         (bit_o),
  .bit_valid_o   (bit_valid_o),
  .burst_active_o(burst_active_o)
);

// File: tb/tb_manchester_rx.sv
module tb_manchester_rx;
  localparam int BIT_CLKS = 16;
  localparam int HALF = BIT_CLKS / 2;
  localparam int TIMEOUT_BITS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_o, bit_valid_o, burst_active_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    exp_q[$];
  string tag = "R1";
  bit    done = 1'b0;
  bit    prev_valid = 1'b0;

  always #4 clk = ~clk;

  manchester_rx #(.BIT_CLKS(BIT_CLKS), .TIMEOUT_BITS(TIMEOUT_BITS)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .line_i        (line),
    .bit_o         (bit_o),
    .bit_valid_o   (bit_valid_o),
    .burst_active_o(burst_active_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold(input bit lvl, input int n);
    line = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    exp_q.push_back(b);
    hold(!b, HALF);
    hold(b, HALF);
  endtask

  task automatic send_word(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  // preamble 0 plus arming latency checks
  task automatic start_frame();
    tag = "R4";
    exp_q.push_back(1'b0);
    line = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(burst_active_o == 1'b0, "R2", "active before 3rd edge",
          int'(burst_active_o), 0);
    @(negedge clk);
    check(burst_active_o == 1'b1, "R2", "active at 3rd edge",
          int'(burst_active_o), 1);
    repeat (HALF - 3) @(negedge clk);
    hold(1'b0, HALF);
  endtask

  task automatic end_frame();
    tag = "R7";
    line = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    check(burst_active_o == 1'b1, "R7", "active held before timeout",
          int'(burst_active_o), 1);
    repeat (TIMEOUT_BITS * BIT_CLKS) @(negedge clk);
    check(burst_active_o == 1'b0, "R7", "active dropped after timeout",
          int'(burst_active_o), 0);
    check(exp_q.size() == 0, "R3", "bits still expected", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid_o && prev_valid)
        check(1'b0, "R5", "strobe wider than one cycle", 2, 1);
      if (bit_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, tag, "unexpected bit strobe", 1, 0);
        end else begin
          automatic bit e = exp_q.pop_front();
          check(bit_o == e, tag, "decoded bit", int'(bit_o), int'(e));
        end
      end
      prev_valid = bit_valid_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bit_o == 1'b0, "R1", "bit_o in reset", int'(bit_o), 0);
    check(bit_valid_o == 1'b0, "R1", "bit_valid_o in reset", int'(bit_valid_o), 0);
    check(burst_active_o == 1'b0, "R1", "burst_active_o in reset",
          int'(burst_active_o), 0);
    rst_n = 1'b1;
    tag = "R2";
    hold(1'b0, 20);
    check(burst_active_o == 1'b0, "R2", "idle with quiet line",
          int'(burst_active_o), 0);

    // burst 1: plain data, includes back-to-back zeros and ones
    start_frame();
    tag = "R3";
    send_word(16'b1001_1100, 8);
    end_frame();

    // burst 2: a bit period with no mid-bit transition
    start_frame();
    tag = "R3";
    send_bit(1'b1);
    send_bit(1'b0);
    tag = "R6";
    hold(1'b0, BIT_CLKS);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    end_frame();

    // burst 3: new phase against the clock
    hold(1'b0, 5);
    start_frame();
    tag = "R8";
    send_word(16'b1100_10, 6);
    end_frame();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule